// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block holds the 8-bit status register of a serial flash controller and decides whether writes are allowed. It does not shift serial data and does not time the array. The command front-end sends it single-cycle events, one for each decoded instruction: write-enable, write-disable, status-write arm, and status-write with its data byte. A separate pulse covers any other instruction. The executor supplies three more signals: the busy level, the start of auto-increment programming, and its completion events. The write-protect pin level also comes in as an input.

The unit keeps the write-enable latch and the two protection-level bits. It also keeps the lock bit that freezes those bits while the write-protect pin is low. A status write is accepted only when the instruction just before it was the arming instruction. Any instruction between the two drops the arming. Idle cycles between them do not.

The protection check is combinational. The caller gives the highest byte address that a program or erase would touch. The unit raises a flag if any part of that target lies in the protected top region.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status byte is 8'h0C (both protection-level bits at 1, every other bit 0), and `wel_o` is 0.
- R2: Status byte layout: bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protection level, bits 5:4 always read 0, bit 6 is auto-increment mode, and bit 7 is the lock. Bit 0 shows `busy_i` one clock after it is sampled. Data written to bits 5:4, 6, 1 or 0 by a status write has no effect.
- R3: `ev_wren_i` sets the write-enable latch at the next clock. `ev_wrdi_i` clears both the latch and the auto-increment bit.
- R4: `ev_wr_done_i` clears the write-enable latch. `aai_top_i` clears both the latch and the auto-increment bit. A clear wins over a set in the same cycle.
- R5: A status write whose previous instruction was the arm instruction loads bit 7, bit 3 and bit 2 from the data byte at the next clock, when not locked. Idle cycles between the two instructions do not disarm.
- R6: A status write is ignored if it was not armed. This includes the case where any other instruction (`ev_wren_i`, `ev_wrdi_i`, `ev_other_i`, or an earlier status write) came after the arm instruction.
- R7: While `wp_n_i` is 0 and the lock bit is 1, a status write is ignored. While `wp_n_i` is 1, a status write may change all three bits, including clearing the lock. The pin is sampled in the same cycle as `ev_wrsr_i`.
- R8: With `wp_n_i` at 0 and the lock bit at 0, one status write can set the lock and change the protection level together. The lock bit never falls while `wp_n_i` is 0.
- R9: `prot_hit_o` depends on the protection level and `top_addr_i`, with default `ADDR_W`=17. Level 00 never flags. Level 01 flags when `top_addr_i` ≥ 'h18000. Level 10 flags when `top_addr_i` ≥ 'h10000. Level 11 always flags.
- R10: `aai_start_i` sets status bit 6 at the next clock, unless a clear event arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_wren_i | input | 1 | Write-enable instruction decoded (pulse) |
| ev_wrdi_i | input | 1 | Write-disable instruction decoded (pulse) |
| ev_ewsr_i | input | 1 | Status-write arm instruction decoded (pulse) |
| ev_wrsr_i | input | 1 | Status-write instruction completed (pulse) |
| wrsr_data_i | input | 8 | Data byte of the status write |
| ev_other_i | input | 1 | Any other instruction completed (pulse) |
| ev_wr_done_i | input | 1 | Program or erase operation finished (pulse) |
| aai_start_i | input | 1 | Auto-increment programming entered (pulse) |
| aai_top_i | input | 1 | Auto-increment reached the top address (pulse) |
| busy_i | input | 1 | Executor busy level |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| top_addr_i | input | ADDR_W | Highest byte address of the write target |
| status_o | output | 8 | Status byte |
| wel_o | output | 1 | Write-enable latch |
| prot_hit_o | output | 1 | Target overlaps the protected region |

## Verification
The bench uses the default `ADDR_W` of 17, so the array is 128 KiB. With that width, the quarter boundary 'h18000 and the half boundary 'h10000 are exact addresses that the bench probes on both sides. The narrow address space also means random targets fall into every region often. The random phase toggles the pin, the arm instruction and the lock together, so it reaches the locked, pin-released and lock-while-unlocked cases many times.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

    typedef struct packed {
        logic       lock;
        logic       aai;
        logic [1:0] level;
        logic       wel;
        logic       busy;
        logic       armed;
    } sreg_state_t;

    // bits a status write may alter: lock and the two level bits
    localparam logic [7:0] SR_WR_MASK = 8'h8C;
    localparam logic [7:0] SR_RESET   = 8'h0C;

    function automatic logic [7:0] pack_status(sreg_state_t s);
        return {s.lock, s.aai, 2'b00, s.level, s.wel, s.busy};
    endfunction

endpackage

// File: rtl/sreg_range_check.sv
module sreg_range_check #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        level_i,
    input  logic [ADDR_W-1:0] top_addr_i,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

    // protected area is always the top of the array, so the target's
    // highest address alone decides the overlap
    always_comb begin
        unique case (level_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = (top_addr_i >= QTR_BASE);
            2'b10:   hit_o = (top_addr_i >= HALF_BASE);
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sreg_core.sv
module sreg_core
    import sreg_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_wren_i,
    input  logic        ev_wrdi_i,
    input  logic        ev_ewsr_i,
    input  logic        ev_wrsr_i,
    input  logic [7:0]  wrsr_data_i,
    input  logic        ev_other_i,
    input  logic        ev_wr_done_i,
    input  logic        aai_start_i,
    input  logic        aai_top_i,
    input  logic        busy_i,
    input  logic        wp_n_i,
    output sreg_state_t state_o
);
    sreg_state_t st_d, st_q;
    logic [7:0]  wr_masked;
    logic        any_instr;
    logic        wr_allowed;

    always_comb begin
        st_d       = st_q;
        wr_masked  = wrsr_data_i & SR_WR_MASK;
        any_instr  = ev_wren_i | ev_wrdi_i | ev_ewsr_i | ev_wrsr_i | ev_other_i;
        wr_allowed = ev_wrsr_i & st_q.armed & (wp_n_i | ~st_q.lock);

        st_d.busy = busy_i;
        if (ev_wren_i)   st_d.wel = 1'b1;
        if (aai_start_i) st_d.aai = 1'b1;
        if (ev_wrdi_i) begin
            st_d.wel = 1'b0;
            st_d.aai = 1'b0;
        end
        if (ev_wr_done_i) st_d.wel = 1'b0;
        if (aai_top_i) begin
            st_d.wel = 1'b0;
            st_d.aai = 1'b0;
        end
        if (wr_allowed) begin
            st_d.lock  = wr_masked[7];
            st_d.level = wr_masked[3:2];
        end
        if (any_instr) st_d.armed = ev_ewsr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.level <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

    // R3
    wren_sets_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wren_i && !ev_wrdi_i && !ev_wr_done_i && !aai_top_i |=> state_o.wel);

    // R4
    done_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr_done_i |=> !state_o.wel);

    // R6
    unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrsr_i && !state_o.armed |=> $stable({state_o.lock, state_o.level}));

    // R7
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrsr_i && !wp_n_i && state_o.lock |=> $stable({state_o.lock, state_o.level}));

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_o.lock) |-> $past(wp_n_i));

    // R10
    aai_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aai_start_i && !ev_wrdi_i && !aai_top_i |=> state_o.aai);
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_wren_i,
    input  logic              ev_wrdi_i,
    input  logic              ev_ewsr_i,
    input  logic              ev_wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              ev_other_i,
    input  logic              ev_wr_done_i,
    input  logic              aai_start_i,
    input  logic              aai_top_i,
    input  logic              busy_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] top_addr_i,
    output logic [7:0]        status_o,
    output logic              wel_o,
    output logic              prot_hit_o
);
    sreg_state_t st;

    sreg_core i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_wren_i    (ev_wren_i),
        .ev_wrdi_i    (ev_wrdi_i),
        .ev_ewsr_i    (ev_ewsr_i),
        .ev_wrsr_i    (ev_wrsr_i),
        .wrsr_data_i  (wrsr_data_i),
        .ev_other_i   (ev_other_i),
        .ev_wr_done_i (ev_wr_done_i),
        .aai_start_i  (aai_start_i),
        .aai_top_i    (aai_top_i),
        .busy_i       (busy_i),
        .wp_n_i       (wp_n_i),
        .state_o      (st)
    );

    sreg_range_check #(.ADDR_W(ADDR_W)) i_range (
        .level_i    (st.level),
        .top_addr_i (top_addr_i),
        .hit_o      (prot_hit_o)
    );

    assign status_o = pack_status(st);
    assign wel_o    = st.wel;

    // R9
    full_level_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b11 |-> prot_hit_o);

    // R9
    no_level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b00 |-> !prot_hit_o);
endmodule

// File: tb/test_sreg_guard.sv
module test_sreg_guard;
    localparam int ADDR_W = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_wren = 0, ev_wrdi = 0, ev_ewsr = 0, ev_wrsr = 0, ev_other = 0;
    logic ev_done = 0, aai_start = 0, aai_top = 0, busy = 0, wp_n = 1;
    logic [7:0] wdata = 8'h00;
    logic [ADDR_W-1:0] taddr = '0;
    logic [7:0] status;
    logic wel, prot;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic m_lock, m_aai, m_wel, m_busy, m_armed;
    logic [1:0] m_level;

    always #4 clk = ~clk;

    sreg_guard #(.ADDR_W(ADDR_W)) i_sreg_guard (
        .clk(clk), .rst_n(rst_n),
        .ev_wren_i(ev_wren), .ev_wrdi_i(ev_wrdi), .ev_ewsr_i(ev_ewsr),
        .ev_wrsr_i(ev_wrsr), .wrsr_data_i(wdata), .ev_other_i(ev_other),
        .ev_wr_done_i(ev_done), .aai_start_i(aai_start), .aai_top_i(aai_top),
        .busy_i(busy), .wp_n_i(wp_n), .top_addr_i(taddr),
        .status_o(status), .wel_o(wel), .prot_hit_o(prot)
    );

    function automatic logic [7:0] exp_status();
        return {m_lock, m_aai, 2'b00, m_level, m_wel, m_busy};
    endfunction

    function automatic logic exp_prot(logic [1:0] lv, logic [ADDR_W-1:0] a);
        case (lv)
            2'b00:   return 1'b0;
            2'b01:   return a >= 17'h18000;
            2'b10:   return a >= 17'h10000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_reset();
        m_lock = 0; m_aai = 0; m_level = 2'b11; m_wel = 0; m_busy = 0; m_armed = 0;
    endtask

    task automatic model_step();
        logic ok;
        ok = ev_wrsr && m_armed && (wp_n || !m_lock);
        m_busy = busy;
        if (ev_wren)   m_wel = 1;
        if (aai_start) m_aai = 1;
        if (ev_wrdi)   begin m_wel = 0; m_aai = 0; end
        if (ev_done)   m_wel = 0;
        if (aai_top)   begin m_wel = 0; m_aai = 0; end
        if (ok) begin m_lock = wdata[7]; m_level = wdata[3:2]; end
        if (ev_wren || ev_wrdi || ev_ewsr || ev_wrsr || ev_other) m_armed = ev_ewsr;
    endtask

    task automatic clear_pulses();
        ev_wren = 0; ev_wrdi = 0; ev_ewsr = 0; ev_wrsr = 0; ev_other = 0;
        ev_done = 0; aai_start = 0; aai_top = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_prot(string req, logic [ADDR_W-1:0] a);
        taddr = a;
        #1;
        check(req, {7'd0, prot}, {7'd0, exp_prot(m_level, a)});
    endtask

    task automatic arm_write(logic [7:0] d);
        ev_ewsr = 1; tick();
        ev_wrsr = 1; wdata = d; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset value
        check("R1", status, 8'h0C);
        check("R1", {7'd0, wel}, 8'h00);
        // R9 full level
        check_prot("R9", '0);

        // R6 status write without arming
        ev_wrsr = 1; wdata = 8'h00; tick();
        check("R6", status, 8'h0C);

        // R5 armed write clears level
        wp_n = 1; arm_write(8'h00);
        check("R5", status, 8'h00);
        check_prot("R9", 17'h1FFFF);

        // R2 reserved and read-only bits ignore data
        arm_write(8'hFF);
        check("R2", status, 8'h8C);

        // R7 locked with pin low
        wp_n = 0; arm_write(8'h00);
        check("R7", status, 8'h8C);
        // R7 pin high releases lock
        wp_n = 1; arm_write(8'h04);
        check("R7", status, 8'h04);

        // R6 other instruction between arm and write
        ev_ewsr = 1; tick();
        ev_wren = 1; tick();
        ev_wrsr = 1; wdata = 8'h08; tick();
        check("R6", status, 8'h06);
        ev_wrdi = 1; tick();

        // R5 idle cycles keep the arming
        ev_ewsr = 1; tick();
        tick(); tick(); tick();
        ev_wrsr = 1; wdata = 8'h08; tick();
        check("R5", status, 8'h08);
        check_prot("R9", 17'h0FFFF);
        check_prot("R9", 17'h10000);

        // R8 lock and level in one write with pin low
        wp_n = 0; arm_write(8'h84);
        check("R8", status, 8'h84);
        check_prot("R9", 17'h17FFF);
        check_prot("R9", 17'h18000);

        // R3 / R2 latch and busy mirror
        ev_wren = 1; busy = 1; tick();
        check("R3", status, 8'h87);
        check("R3", {7'd0, wel}, 8'h01);
        busy = 0; ev_done = 1; tick();
        check("R4", status, 8'h84);

        // R10 then R3 disable clears both
        aai_start = 1; ev_wren = 1; tick();
        check("R10", status, 8'hC6);
        ev_wrdi = 1; tick();
        check("R3", status, 8'h84);
        // R4 top address clears both, and clear wins over set
        aai_start = 1; ev_wren = 1; tick();
        aai_top = 1; ev_wren = 1; tick();
        check("R4", status, 8'h84);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel   = $urandom_range(0, 9);
            wp_n  = $urandom_range(0, 3) != 0;
            busy  = $urandom_range(0, 1);
            wdata = 8'($urandom);
            case (sel)
                0: ev_wren = 1;
                1: ev_wrdi = 1;
                2, 3: ev_ewsr = 1;
                4, 5: ev_wrsr = 1;
                6: ev_other = 1;
                default: ;
            endcase
            ev_done   = $urandom_range(0, 15) == 0;
            aai_start = $urandom_range(0, 7) == 0;
            aai_top   = $urandom_range(0, 31) == 0;
            tick();
            // R2 R3 R4 R5 R6 R7 R8 R10 against reference
            check("R5", status, exp_status());
            check("R3", {7'd0, wel}, {7'd0, m_wel});
            check_prot("R9", ADDR_W'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule